// File: doc/BRIEF.md
# Paged-Window Serial Flash Byte Bridge

This block gives a host a five-byte I/O window through which it can drive a serial flash one byte at a time. The window's 16-bit base is set on two configuration inputs, with the high byte on the first. The first four window offsets hold the bytes of a 32-bit pointer, least significant byte at the lowest offset. The fifth offset is a data port. What a data-port access does depends on the page the pointer selects. One page is a "release" page: any write there raises chip select. A second page is a "shift" page: a write there lowers chip select and sends the byte on MOSI. A read there keeps chip select low and returns a byte captured from MISO.

A flash transaction is driven as follows. The host writes once to the release page. It then writes the command bytes and reads the response bytes on the shift page. It closes with a second write to the release page. Each access is a request held by the host until a one-cycle acknowledge. Shift-page accesses carry out a full mode-0 serial byte transfer before they are acknowledged, and a busy output is high for that whole transfer.

Top module: `spi_window_bridge`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0 and ack is 0.
- R2: Requests at base+0..base+3, where base = {base_hi, base_lo}, write or read pointer byte 0..3, and byte 0 holds pointer bits 7:0. The request is acknowledged with a single-cycle ack one cycle after it is presented. A read returns the byte on rdata during the ack.
- R3: A data-port (base+4) write while pointer bits 31:8 equal 0xFFFFFE sets cs_n to 1 and produces no sclk pulse. The written value is ignored.
- R4: A data-port write while pointer bits 31:8 equal 0xFFFFFD sets cs_n to 0 and sends the byte MSB first in mode 0. The transfer has exactly 8 sclk rising edges, all with cs_n low, and MOSI is stable while sclk is high.
- R5: A data-port read on page 0xFFFFFD keeps cs_n low. It sends 0xFF on MOSI and returns on rdata the 8 MISO bits sampled on the sclk rising edges, first bit as the MSB.
- R6: During a shift-page transfer busy is 1 and ack stays 0. The ack comes at least 8*SCK_DIV cycles after the request.
- R7: A data-port access on any other page leaves cs_n unchanged, produces no sclk pulse, and a read returns 0xFF.
- R8: A request whose address is outside base..base+4 is never acknowledged and changes no pointer byte.
- R9: sclk is 0 whenever no transfer is running, and each sclk high phase lasts SCK_DIV/2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_hi | input | 8 | High byte of the window base I/O address |
| base_lo | input | 8 | Low byte of the window base I/O address |
| req | input | 1 | Host access request, held until ack |
| wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | 16 | Host I/O address of the access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, valid while ack is high |
| ack | output | 1 | One-cycle access completion |
| busy | output | 1 | Serial byte transfer in progress |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench reads the pointer bytes back at each offset. A design that reversed the byte order would return 0x78 where 0x12 is expected. Release-page writes go out with non-zero data and must not make a single sclk edge. A design that treated them as shift writes would toggle the clock and keep chip select low. Reads on a foreign page while chip select is low check that cs_n is left alone and that 0xFF comes back, which catches a decode that matches only part of the page. The bench also measures every sclk high phase and counts acknowledge latency. A divider off by one, or an acknowledge raised before the eighth falling edge, both show up as timing mismatches.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } swb_state_e;

  typedef enum logic [1:0] {
    PG_RAISE = 2'd0,
    PG_SHIFT = 2'd1,
    PG_OTHER = 2'd2
  } swb_page_e;

  // Offset of a host address inside the window (wraps below the base).
  function automatic logic [15:0] window_offset(input logic [15:0] addr,
                                                input logic [15:0] base);
    return addr - base;
  endfunction

  // Classify the pointer's upper 24 bits into one of the page kinds.
  function automatic swb_page_e page_of(input logic [31:0] ptr,
                                        input logic [23:0] raise_pg,
                                        input logic [23:0] shift_pg);
    if (ptr[31:8] == raise_pg)      return PG_RAISE;
    else if (ptr[31:8] == shift_pg) return PG_SHIFT;
    else                            return PG_OTHER;
  endfunction

endpackage

// File: rtl/swb_ptr_regs.sv
module swb_ptr_regs #(
  parameter int NBYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NBYTES)-1:0]  sel,
  input  logic [7:0]                 wdata,
  output logic [8*NBYTES-1:0]        ptr
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr[8*g +: 8] <= 8'h00;
      else if (wr_en && (sel == g[$clog2(NBYTES)-1:0]))
        ptr[8*g +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/swb_spi_shifter.sv
module swb_spi_shifter #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = $clog2(HALF) + 1;

  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    sreg;

  assign mosi = sreg[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      cnt     <= '0;
      nbit    <= '0;
      sreg    <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sclk   <= 1'b0;
        cnt    <= '0;
        nbit   <= '0;
        sreg   <= tx_byte;
      end else if (active) begin
        if (cnt == CW'(HALF - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (nbit == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              nbit <= nbit + 3'd1;
              sreg <= {sreg[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
  import swb_pkg::*;
#(
  parameter int          SCK_DIV    = 4,
  parameter logic [23:0] RAISE_PAGE = 24'hFFFFFE,
  parameter logic [23:0] SHIFT_PAGE = 24'hFFFFFD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  base_hi,
  input  logic [7:0]  base_lo,
  input  logic        req,
  input  logic        wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        ack,
  output logic        busy,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int PTR_BYTES = 4;
  localparam int SPAN      = PTR_BYTES + 1;

  swb_state_e  state;
  logic [15:0] off;
  logic        hit, accept, reg_wr, data_acc;
  logic [31:0] ptr;
  swb_page_e   pg;
  logic        evt_cs_raise, evt_shift_start;
  logic        sh_active, sh_done;
  logic [7:0]  sh_rx;
  logic [7:0]  rdata_q;
  logic        cs_n_q;

  assign off      = window_offset(io_addr, {base_hi, base_lo});
  assign hit      = off < 16'(SPAN);
  assign accept   = req && hit && (state == ST_IDLE);
  assign reg_wr   = accept && wr && (off < 16'(PTR_BYTES));
  assign data_acc = accept && (off == 16'(PTR_BYTES));
  assign pg       = page_of(ptr, RAISE_PAGE, SHIFT_PAGE);

  assign evt_cs_raise    = data_acc && wr && (pg == PG_RAISE);
  assign evt_shift_start = data_acc && (pg == PG_SHIFT);

  swb_ptr_regs #(.NBYTES(PTR_BYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .sel   (off[1:0]),
    .wdata (wdata),
    .ptr   (ptr)
  );

  swb_spi_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (evt_shift_start),
    .tx_byte (wr ? wdata : 8'hFF),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .active  (sh_active),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rdata_q <= 8'h00;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= evt_shift_start ? ST_XFER : ST_DONE;
        ST_XFER: if (sh_done) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
      if (accept && !wr && (off < 16'(PTR_BYTES)))
        rdata_q <= ptr[8*off[1:0] +: 8];
      else if (data_acc && !evt_shift_start)
        rdata_q <= 8'hFF;
      else if (sh_done)
        rdata_q <= sh_rx;
      if (evt_cs_raise)
        cs_n_q <= 1'b1;
      else if (evt_shift_start)
        cs_n_q <= 1'b0;
    end
  end

  assign ack   = (state == ST_DONE);
  assign busy  = (state == ST_XFER) || sh_active;
  assign rdata = rdata_q;
  assign cs_n  = cs_n_q;
endmodule

// File: rtl/spi_window_bridge_chk.sv
module spi_window_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic ack,
  input logic evt_cs_raise,
  input logic evt_shift_start
);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  assert_edge_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_cs_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(evt_cs_raise));
  assert_cs_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(evt_shift_start));
endmodule

bind spi_window_bridge spi_window_bridge_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cs_n            (cs_n),
  .sclk            (sclk),
  .mosi            (mosi),
  .busy            (busy),
  .ack             (ack),
  .evt_cs_raise    (evt_cs_raise),
  .evt_shift_start (evt_shift_start)
);

// File: tb/spi_window_bridge_test.sv
`timescale 1ns/1ps
module spi_window_bridge_test;
  localparam int DIV  = 4;
  localparam int TCLK = 20;
  localparam logic [15:0] BASE = 16'h1240;

  logic clk = 0, rst_n = 0, req = 0, wr = 0, miso;
  logic [15:0] io_addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic ack, busy, cs_n, sclk, mosi;

  int checks = 0, errors = 0, sclk_edges = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slave_sh = 8'h00;
  logic [7:0] mbyte = 8'h00;
  int mcnt = 0;
  realtime t_rise = 0;

  always #(TCLK/2) clk = ~clk;
  assign miso = slave_sh[7];

  spi_window_bridge #(.SCK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .base_hi(BASE[15:8]), .base_lo(BASE[7:0]),
    .req(req), .wr(wr), .io_addr(io_addr), .wdata(wdata), .rdata(rdata),
    .ack(ack), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: collect MOSI bits on sclk rise, compare to scoreboard queue.
  always @(posedge sclk) begin
    sclk_edges++;
    t_rise = $realtime;
    if (cs_n) chk(0, "R4 sclk edge with cs_n high", 1, 0);
    mbyte = {mbyte[6:0], mosi};
    mcnt++;
    if (mcnt == 8) begin
      mcnt = 0;
      if (exp_q.size() == 0) chk(0, "R4 unexpected MOSI byte", mbyte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(mbyte == e, "R4/R5 MOSI byte", mbyte, e);
      end
    end
  end

  always @(negedge sclk) begin
    chk(($realtime - t_rise) == real'(DIV/2*TCLK), "R9 sclk high width",
        int'($realtime - t_rise), DIV/2*TCLK);
    slave_sh = {slave_sh[6:0], 1'b0};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic host(input logic [15:0] a, input bit w, input logic [7:0] d,
                      output logic [7:0] r, output int n, output bit busy_ok);
    @(negedge clk);
    io_addr = a; wr = w; wdata = d; req = 1;
    n = 0; busy_ok = 1; r = 8'h00;
    while (1) begin
      @(negedge clk);
      n++;
      if (ack) begin r = rdata; break; end
      if (!busy) busy_ok = 0;
      if (n > 2000) begin chk(0, "R2 ack timeout", n, 0); break; end
    end
    req = 0;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    logic [7:0] r; int n; bit b;
    for (int i = 0; i < 4; i++) host(BASE + 16'(i), 1, p[8*i +: 8], r, n, b);
  endtask

  task automatic shift_wr(input logic [7:0] d);
    logic [7:0] r; int n; bit b;
    exp_q.push_back(d);
    host(BASE + 16'd4, 1, d, r, n, b);
    chk(cs_n == 0, "R4 cs_n low after shift write", cs_n, 0);
    chk(n >= 8*DIV, "R6 ack latency", n, 8*DIV);
    chk(b, "R6 busy during transfer", b, 1);
  endtask

  task automatic shift_rd(input logic [7:0] s);
    logic [7:0] r; int n; bit b;
    exp_q.push_back(8'hFF);
    slave_sh = s;
    host(BASE + 16'd4, 0, 8'h00, r, n, b);
    chk(r == s, "R5 read byte", r, s);
    chk(cs_n == 0, "R5 cs_n stays low", cs_n, 0);
  endtask

  initial begin
    logic [7:0] r; int n; bit b; int e0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && ack == 0, "R1 reset state",
        {cs_n, sclk, busy, ack}, 4'b1000);
    rst_n = 1;

    set_ptr(32'h78563412);
    for (int i = 0; i < 4; i++) begin
      host(BASE + 16'(i), 0, 8'h00, r, n, b);
      chk(r == 8'(8'h12 + 8'(i * 8'h22)), "R2 pointer byte readback", r, 8'h12 + i*8'h22);
      chk(n == 1, "R2 ack one cycle after request", n, 1);
    end

    set_ptr(32'hFFFFFE00);
    e0 = sclk_edges;
    host(BASE + 16'd4, 1, 8'h5A, r, n, b);
    chk(cs_n == 1, "R3 cs_n high after release write", cs_n, 1);
    chk(sclk_edges == e0, "R3 no sclk on release write", sclk_edges - e0, 0);

    set_ptr(32'hFFFFFD10);
    shift_wr(8'h9F);
    shift_wr(8'h03);
    shift_wr(8'h00);
    shift_rd(8'hC3);
    shift_rd(8'h5A);

    set_ptr(32'hFFFFFC00);
    e0 = sclk_edges;
    host(BASE + 16'd4, 0, 8'h00, r, n, b);
    chk(r == 8'hFF, "R7 foreign-page read", r, 8'hFF);
    host(BASE + 16'd4, 1, 8'hA5, r, n, b);
    chk(cs_n == 0, "R7 cs_n unchanged (low)", cs_n, 0);
    chk(sclk_edges == e0, "R7 no sclk on foreign page", sclk_edges - e0, 0);

    set_ptr(32'hFFFFFE00);
    host(BASE + 16'd4, 1, 8'h00, r, n, b);
    chk(cs_n == 1, "R3 transaction closed", cs_n, 1);

    set_ptr(32'h0000FD00);
    e0 = sclk_edges;
    host(BASE + 16'd4, 1, 8'h77, r, n, b);
    chk(cs_n == 1 && sclk_edges == e0, "R7 partial page match ignored",
        sclk_edges - e0, 0);

    foreach (exp_q[i]) ;
    @(negedge clk);
    io_addr = BASE + 16'd5; wr = 1; wdata = 8'hEE; req = 1;
    b = 0;
    repeat (20) begin @(negedge clk); if (ack) b = 1; end
    io_addr = BASE - 16'd1;
    repeat (20) begin @(negedge clk); if (ack) b = 1; end
    req = 0;
    chk(!b, "R8 no ack outside window", b, 0);
    host(BASE, 0, 8'h00, r, n, b);
    chk(r == 8'h00, "R8 pointer unchanged", r, 8'h00);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all bytes seen on MOSI", exp_q.size(), 0);
    chk(sclk == 0, "R9 sclk idle low", sclk, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule